// File: doc/BRIEF.md
# Eight-Channel Transmit Queue Arbiter

This block decides which of eight transmit queues may hand its next frame to the MAC. Each queue raises a request line. The arbiter grants one queue per frame and holds that grant until the frame's last word has been accepted. A run-time mode input selects one of two policies. In fixed priority, the highest channel index wins. In round-robin, the search starts just after the channel granted last.

Two conditions can stop new grants. The first is a received pause condition, which blocks new grants while the link is in full duplex with transmit flow control switched on. A frame already in flight always runs to its end. The second is a per-channel teardown command, which takes a channel out of arbitration at the next frame boundary. The block then reports completion with a one-cycle pulse on that channel's done line.

Top module: `txq_arbiter`

## Requirements
- R1: `gnt_vec_o` is always zero or one-hot, and when `gnt_vld_o` is 1 its set bit is at index `gnt_id_o`. When `gnt_vld_o` is 0, `gnt_vec_o` is zero.
- R2: Once a channel is granted, the grant stays on that channel, whatever the requests do, until `frame_end_i` is sampled high.
- R3: When `frame_end_i` is high with a grant active, `gnt_vld_o` is 0 in the next cycle. A new grant can appear no earlier than one cycle after that.
- R4: With no grant active, no block in force and at least one eligible requester, a grant appears on the cycle after the request is seen. Only a channel whose `req_i` bit is high can be granted.
- R5: With `sel_rr_i` = 0 (fixed priority), the eligible requester with the highest index wins: channel 7 first, channel 0 last.
- R6: With `sel_rr_i` = 1 (round-robin), the eligible requester nearest above the last granted channel wins, wrapping from 7 to 0. After reset, the search starts at channel 0.
- R7: While `pause_i`, `full_dup_i` and `tx_fc_en_i` are all 1, no new grant is issued. If either enable is 0, `pause_i` has no effect. A frame already granted keeps its grant until its end.
- R8: `td_req_i` with a 3-bit channel number on `td_chan_i` marks that channel for teardown. The channel is not granted while the mark is pending.
- R9: A marked channel that is not the current owner pulses its `td_done_o` bit for one cycle, two cycles after the command is sampled.
- R10: A marked channel that is the current owner keeps its grant until its frame ends. Its `td_done_o` bit then pulses one cycle after the grant drops.
- R11: After reset, `gnt_vld_o`, `gnt_vec_o` and `td_done_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | NUM_CH | Per-queue frame-ready requests |
| sel_rr_i | input | 1 | 0 selects fixed priority, 1 selects round-robin |
| full_dup_i | input | 1 | Link is in full duplex |
| tx_fc_en_i | input | 1 | Transmit flow control is enabled |
| pause_i | input | 1 | Received pause condition is active |
| frame_end_i | input | 1 | Last word of the granted frame is accepted this cycle |
| td_req_i | input | 1 | Teardown command strobe |
| td_chan_i | input | CH_W | Channel number of the teardown command |
| gnt_vld_o | output | 1 | A grant is active |
| gnt_id_o | output | CH_W | Index of the granted channel |
| gnt_vec_o | output | NUM_CH | One-hot grant vector |
| td_done_o | output | NUM_CH | One-cycle teardown completion pulse for each channel |

## Verification
The bench builds the block with its defaults, NUM_CH = 8 and CH_W = 3. These values reach the priority extremes (channel 7 over channel 0) and the round-robin wrap from 7 back to 0. They also make all three bits of the teardown channel field significant. With eight channels, the bench can show that a torn-down owner is passed over in favour of a lower channel. It can also show the pause gate being tested with each enable dropped in turn.

// File: rtl/txq_arb_pkg.sv
`timescale 1ns/1ps
package txq_arb_pkg;
  typedef enum logic {
    SEL_FIXED = 1'b0,
    SEL_RR    = 1'b1
  } sel_mode_e;
endpackage

// File: rtl/txq_arb_select.sv
`timescale 1ns/1ps
// Combinational winner search over the eligible channel mask.
module txq_arb_select
  import txq_arb_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CH_W   = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] elig_i,
  input  sel_mode_e         mode_i,
  input  logic [CH_W-1:0]   last_i,
  output logic              found_o,
  output logic [CH_W-1:0]   pick_o
);

  always_comb begin
    int idx;
    found_o = 1'b0;
    pick_o  = '0;
    idx     = 0;
    if (mode_i == SEL_FIXED) begin
      // ascending scan: the last hit is the highest index
      for (int i = 0; i < int'(NUM_CH); i++) begin
        if (elig_i[i]) begin
          found_o = 1'b1;
          pick_o  = CH_W'(i);
        end
      end
    end else begin
      // descending offsets: the last hit is the nearest channel after last_i
      for (int off = int'(NUM_CH); off >= 1; off--) begin
        idx = (int'(last_i) + off) % int'(NUM_CH);
        if (elig_i[idx]) begin
          found_o = 1'b1;
          pick_o  = CH_W'(idx);
        end
      end
    end
  end

endmodule

// File: rtl/txq_arb_teardown.sv
`timescale 1ns/1ps
// Tracks pending teardown marks and emits completion pulses at frame boundaries.
module txq_arb_teardown #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              td_req_i,
  input  logic [CH_W-1:0]   td_chan_i,
  input  logic              act_i,
  input  logic [CH_W-1:0]   own_i,
  output logic [NUM_CH-1:0] pend_o,
  output logic [NUM_CH-1:0] done_o
);

  logic [NUM_CH-1:0] pend_q, pend_n;
  logic [NUM_CH-1:0] done_q, done_n;
  logic [NUM_CH-1:0] own_mask;
  logic [NUM_CH-1:0] set_vec;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign own_mask[c] = act_i && (own_i == CH_W'(c));
    assign set_vec[c]  = td_req_i && (td_chan_i == CH_W'(c));
  end

  always_comb begin
    done_n = pend_q & ~own_mask;
    pend_n = (pend_q & ~done_n) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      done_q <= '0;
    end else begin
      pend_q <= pend_n;
      done_q <= done_n;
    end
  end

  assign pend_o = pend_q;
  assign done_o = done_q;

  // a completion pulse never lands on the channel that still owns the grant
  AST_TD_DONE_OFF_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q & own_mask) == '0); // R10

endmodule

// File: rtl/txq_arbiter.sv
`timescale 1ns/1ps
module txq_arbiter
  import txq_arb_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req_i,
  input  logic              sel_rr_i,
  input  logic              full_dup_i,
  input  logic              tx_fc_en_i,
  input  logic              pause_i,
  input  logic              frame_end_i,
  input  logic              td_req_i,
  input  logic [CH_W-1:0]   td_chan_i,
  output logic              gnt_vld_o,
  output logic [CH_W-1:0]   gnt_id_o,
  output logic [NUM_CH-1:0] gnt_vec_o,
  output logic [NUM_CH-1:0] td_done_o
);

  localparam logic [CH_W-1:0] LAST_RST = CH_W'(NUM_CH - 1);

  logic              act_q, act_n;
  logic [CH_W-1:0]   own_q, own_n;
  logic [CH_W-1:0]   last_q, last_n;
  logic              st_en;
  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] elig;
  logic              found;
  logic [CH_W-1:0]   pick;
  logic              hold_off;
  sel_mode_e         mode;

  assign mode     = sel_mode_e'(sel_rr_i);
  assign hold_off = pause_i && full_dup_i && tx_fc_en_i;
  assign elig     = req_i & ~pend;

  txq_arb_select #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_sel (
    .elig_i  (elig),
    .mode_i  (mode),
    .last_i  (last_q),
    .found_o (found),
    .pick_o  (pick)
  );

  txq_arb_teardown #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_td (
    .clk       (clk),
    .rst_n     (rst_n),
    .td_req_i  (td_req_i),
    .td_chan_i (td_chan_i),
    .act_i     (act_q),
    .own_i     (own_q),
    .pend_o    (pend),
    .done_o    (td_done_o)
  );

  always_comb begin
    act_n  = act_q;
    own_n  = own_q;
    last_n = last_q;
    st_en  = 1'b0;
    if (act_q) begin
      if (frame_end_i) begin
        act_n = 1'b0;
        st_en = 1'b1;
      end
    end else if (found && !hold_off) begin
      act_n  = 1'b1;
      own_n  = pick;
      last_n = pick;
      st_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      own_q  <= '0;
      last_q <= LAST_RST;
    end else if (st_en) begin
      act_q  <= act_n;
      own_q  <= own_n;
      last_q <= last_n;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_gnt
    assign gnt_vec_o[c] = act_q && (own_q == CH_W'(c));
  end
  assign gnt_vld_o = act_q;
  assign gnt_id_o  = own_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_vec_o)); // R1

  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld_o && !frame_end_i) |=> (gnt_vld_o && $stable(gnt_id_o))); // R2

  AST_EOF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld_o && frame_end_i) |=> !gnt_vld_o); // R3

  AST_GNT_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_vld_o && !(req_i != '0)) |=> !gnt_vld_o); // R4

  AST_PAUSE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_vld_o && pause_i && full_dup_i && tx_fc_en_i) |=> !gnt_vld_o); // R7

  AST_TD_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_vld_o |=> ((gnt_vec_o & $past(pend)) == '0)); // R8

endmodule

// File: tb/txq_arbiter_tb.sv
`timescale 1ns/1ps
module txq_arbiter_tb;
  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] req;
  logic           sel_rr, fdup, fcen, pause, fend, tdreq;
  logic [2:0]     tdch;
  logic           gvld;
  logic [2:0]     gid;
  logic [NCH-1:0] gvec, tddone;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  txq_arbiter #(.NUM_CH(NCH), .CH_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .sel_rr_i(sel_rr),
    .full_dup_i(fdup), .tx_fc_en_i(fcen), .pause_i(pause),
    .frame_end_i(fend), .td_req_i(tdreq), .td_chan_i(tdch),
    .gnt_vld_o(gvld), .gnt_id_o(gid), .gnt_vec_o(gvec), .td_done_o(tddone)
  );

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // expects a grant on channel ch, checking id and vector together
  task automatic chk_gnt(string tag, int ch);
    chk(tag, {7'd0, gvld, gvec}, {7'd0, 1'b1, 8'(1 << ch)});
    chk(tag, 16'(gid), 16'(ch));
  endtask

  task automatic chk_idle(string tag);
    chk(tag, {7'd0, gvld, gvec}, 16'd0);
  endtask

  // asserts frame end for one cycle and checks the grant drops
  task automatic end_frame(string tag);
    fend = 1'b1;
    step();
    fend = 1'b0;
    chk_idle(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; sel_rr = 1'b0; fdup = 1'b0; fcen = 1'b0;
    pause = 1'b0; fend = 1'b0; tdreq = 1'b0; tdch = '0;
    step(2);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 reset grant", {7'd0, gvld, gvec}, 16'd0);
    chk("R11 reset done", 16'(tddone), 16'd0);
  endtask

  task automatic t_fixed();
    do_reset();
    req = 8'b0010_0101;
    step();
    chk_gnt("R5 fixed highest wins (R4)", 5);
    req = 8'b1000_0001;
    step(3);
    chk_gnt("R2 grant held while requests change", 5);
    req = 8'b0000_0101;
    end_frame("R3 grant drops after frame end");
    step();
    chk_gnt("R5 next winner ch2 (R3 one idle cycle)", 2);
    req = 8'b1000_0101;
    end_frame("R3 drop before ch7");
    step();
    chk_gnt("R5 ch7 highest", 7);
    req = '0;
    end_frame("R3 drop ch7");
    step(2);
    chk_idle("R4 no request no grant");
  endtask

  task automatic t_rr();
    do_reset();
    sel_rr = 1'b1;
    req = 8'b1001_0001;
    step();
    chk_gnt("R6 rr starts at ch0 after reset", 0);
    end_frame("R3 rr drop 0");
    step();
    chk_gnt("R6 rr next after 0 is 4", 4);
    end_frame("R3 rr drop 4");
    step();
    chk_gnt("R6 rr next after 4 is 7", 7);
    end_frame("R3 rr drop 7");
    step();
    chk_gnt("R6 rr wraps 7 to 0", 0);
    req = 8'b0000_0001;
    end_frame("R3 rr drop 0 again");
    step();
    chk_gnt("R6 rr sole requester regranted", 0);
    req = '0;
    end_frame("R3 rr final drop");
  endtask

  task automatic t_pause();
    do_reset();
    fdup = 1'b1; fcen = 1'b1; pause = 1'b1;
    req = 8'b0000_1000;
    step(4);
    chk_idle("R7 pause blocks new grant");
    fcen = 1'b0;
    step();
    chk_gnt("R7 pause ignored without flow control", 3);
    fcen = 1'b1;
    step(3);
    chk_gnt("R7 frame in flight keeps grant under pause", 3);
    end_frame("R3 drop under pause");
    step(3);
    chk_idle("R7 still blocked after frame");
    fdup = 1'b0;
    step();
    chk_gnt("R7 pause ignored in half duplex", 3);
    end_frame("R3 drop");
    fdup = 1'b1;
    pause = 1'b0;
    step();
    chk_gnt("R7 grant resumes after pause clears", 3);
    req = '0;
    end_frame("R3 drop final");
  endtask

  task automatic t_teardown();
    do_reset();
    // idle channel teardown
    tdreq = 1'b1; tdch = 3'd6;
    step();
    tdreq = 1'b0;
    chk("R9 no done one cycle after command", 16'(tddone), 16'd0);
    step();
    chk("R9 idle channel done pulse", 16'(tddone), 16'h0040);
    step();
    chk("R9 done is one cycle", 16'(tddone), 16'd0);
    // owner teardown
    req = 8'b0000_0010;
    step();
    chk_gnt("R4 owner ch1 granted", 1);
    tdreq = 1'b1; tdch = 3'd1;
    req = 8'b0000_0011;
    step();
    tdreq = 1'b0;
    step(2);
    chk_gnt("R10 owner keeps grant after teardown", 1);
    chk("R10 no done while owning", 16'(tddone), 16'd0);
    end_frame("R3 owner frame ends");
    chk("R10 no done yet at grant drop", 16'(tddone), 16'd0);
    step();
    chk("R10 owner done after grant drop", 16'(tddone), 16'h0002);
    chk_gnt("R8 torn down ch1 skipped, ch0 wins", 0);
    step();
    chk("R10 done is one cycle", 16'(tddone), 16'd0);
    req = '0;
    end_frame("R3 drop ch0");
  endtask

  initial begin
    t_reset();
    t_fixed();
    t_rr();
    t_pause();
    t_teardown();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule